// File: doc/BRIEF.md
# Dataflow-Graph Opcode Packer

This block converts one preloaded integer dataflow graph into the ordered stream of opcodes a reconfigurable functional unit consumes. Each graph descriptor sits in an internal table selected by a context number. A descriptor gives the graph's source registers in the order the computation needs them, and its result registers in the order they complete. Each result also records how many sources must be present before it is ready. A further table gives, for every count of sources delivered, the latency of the deepest operation that can then finish.

A start pulse names a context. The packer then emits opcodes one per handshake. Each carries the context number, up to `MAX_IN` source fields, a group of result fields, a latency tag and a final-opcode flag. Results are placed as early as their sources allow, under separate caps for opcodes that also carry sources and for opcodes that carry only results. An issue stage uses the stream to replace a run of integer instructions with a few wide operations. The table is written through a small configuration port while the block is idle.

Top module: `dfg_opcode_packer`

## Requirements
- R1: While sources remain, each opcode takes the next min(`MAX_IN`, remaining) sources in need order, placed in source slots 0 upward with the matching `op_in_vld` bits set.
- R2: An opcode that carries sources appends results in completion order. A result is added only if its required-source count is at or below the number of sources encoded up to and including this opcode. At most `MAX_OUT1` results are added, and the scan stops at the first result that is not ready.
- R3: Once all sources are encoded, or if the graph has none, each further opcode is output-only and carries the next min(`MAX_OUT2`, remaining) results.
- R4: An opcode carrying sources has latency equal to the latency entry indexed by the total sources encoded so far. An output-only opcode has latency 1.
- R5: Every opcode of a graph carries that graph's 5-bit context number on `op_ctx`. All 32 contexts are usable.
- R6: `op_last` is high on exactly one opcode per graph: the one after which no sources and no results remain. A graph with no results ends on its last source opcode. A graph with neither sources nor results emits one empty opcode. The block is idle in the cycle after the final handshake.
- R7: While `op_valid` is high and `op_ready` is low, every opcode output holds its value.
- R8: A start pulse while busy is ignored. The running graph continues unchanged and no second graph follows.
- R9: The configuration port writes only while idle, and writes while busy have no effect. `cfg_sel` codes: 0 source count, 1 result count, 2 source register at `cfg_idx`, 3 result register at `cfg_idx`, 4 result's required-source count at `cfg_idx`, 5 latency entry for `cfg_idx` sources encoded.
- R10: A synchronous active-low reset returns the block to idle with `op_valid` and `busy` low. Table contents are kept.
- R11: Unused source and result slots have their valid bits clear and their register fields zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin packing the named context (idle only) |
| start_ctx | input | CTX_W (5) | Context to pack |
| cfg_we | input | 1 | Table write strobe |
| cfg_ctx | input | CTX_W (5) | Context being written |
| cfg_sel | input | 3 | Field code (see R9) |
| cfg_idx | input | CNT_W (4) | Element index within the field |
| cfg_data | input | CFG_DW (8) | Write data |
| busy | output | 1 | Graph being packed |
| op_valid | output | 1 | Opcode presented |
| op_ready | input | 1 | Consumer accepts opcode |
| op_ctx | output | CTX_W (5) | Context number of the opcode |
| op_in_reg | output | MAX_IN*REG_W (15) | Source register fields, slot 0 in low bits |
| op_in_vld | output | MAX_IN (3) | Source slot valid bits |
| op_out_reg | output | OUT_SLOTS*REG_W (10) | Result register fields, slot 0 in low bits |
| op_out_vld | output | OUT_SLOTS (2) | Result slot valid bits |
| op_lat | output | LAT_W (4) | Latency tag |
| op_last | output | 1 | Final opcode of the graph |

## Verification
The assertions check several rules on every cycle. Opcode outputs hold during a stall, and the context stays fixed while busy. The block drops to idle after the final handshake and is idle after reset. Source slots are packed from slot 0, result counts stay within their caps, and output-only opcodes carry latency 1. Other behaviour can only be shown by the bench scenarios, which compare each opcode with an order computed from the descriptor. These cover which results qualify early and where the scan stops, the latency drawn from the table, the number of opcodes and the placement of the final flag. They also show that starts and table writes made while busy leave the running graph and the stored table untouched.

// File: rtl/opk_pkg.sv
// Shared types of the opcode packer.
// Assumes: nothing beyond the field codes listed in the brief.
package opk_pkg;

    // configuration field selector codes
    typedef enum logic [2:0] {
        CF_NIN    = 3'd0,
        CF_NOUT   = 3'd1,
        CF_INREG  = 3'd2,
        CF_OUTREG = 3'd3,
        CF_NEED   = 3'd4,
        CF_LAT    = 3'd5
    } cfg_sel_e;

    // sequencer state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pk_state_e;

endpackage

// File: rtl/gpk_desc_table.sv
// Descriptor storage: one graph description per context.
// Each entry holds the source and result counts, the source registers in need
// order, the result registers in completion order with each result's
// required-source count, and latency entries indexed by sources encoded.
// Assumes: written counts do not exceed MAX_GR (larger values are clamped).
// The table has no reset; contents persist across reset.
module gpk_desc_table #(
    parameter int NUM_CTX = 32,
    parameter int MAX_GR  = 8,
    parameter int REG_W   = 5,
    parameter int LAT_W   = 4,
    parameter int CFG_DW  = 8,
    localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int CNT_W  = $clog2(MAX_GR + 1)
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [CTX_W-1:0]    wr_ctx,
    input  logic [2:0]          wr_sel,
    input  logic [CNT_W-1:0]    wr_idx,
    input  logic [CFG_DW-1:0]   wr_data,
    input  logic [CTX_W-1:0]    rd_ctx,
    output logic [CNT_W-1:0]    rd_n_in,
    output logic [CNT_W-1:0]    rd_n_out,
    output logic [REG_W-1:0]    rd_in_reg  [MAX_GR],
    output logic [REG_W-1:0]    rd_out_reg [MAX_GR],
    output logic [CNT_W-1:0]    rd_need    [MAX_GR],
    output logic [LAT_W-1:0]    rd_lat     [MAX_GR+1]
);
    import opk_pkg::*;

    localparam int IDX_W = (MAX_GR > 1) ? $clog2(MAX_GR) : 1;
    localparam logic [CNT_W-1:0] GR_C = CNT_W'(MAX_GR);

    logic [CNT_W-1:0] n_in_q   [NUM_CTX];
    logic [CNT_W-1:0] n_out_q  [NUM_CTX];
    logic [REG_W-1:0] in_reg_q [NUM_CTX][MAX_GR];
    logic [REG_W-1:0] out_reg_q[NUM_CTX][MAX_GR];
    logic [CNT_W-1:0] need_q   [NUM_CTX][MAX_GR];
    logic [LAT_W-1:0] lat_q    [NUM_CTX][MAX_GR+1];

    cfg_sel_e         sel;
    logic [CNT_W-1:0] cnt_val;
    logic             idx_ok;

    // decode the write: field code, clamped count value, element range check
    always_comb begin
        sel     = cfg_sel_e'(wr_sel);
        cnt_val = (wr_data[CNT_W-1:0] > GR_C) ? GR_C : wr_data[CNT_W-1:0];
        idx_ok  = (wr_idx < GR_C);
    end

    // store one field of one context per write strobe
    always_ff @(posedge clk) begin
        if (wr_en) begin
            case (sel)
                CF_NIN:    n_in_q[wr_ctx] <= cnt_val;
                CF_NOUT:   n_out_q[wr_ctx] <= cnt_val;
                CF_INREG:  if (idx_ok) in_reg_q[wr_ctx][wr_idx[IDX_W-1:0]] <= wr_data[REG_W-1:0];
                CF_OUTREG: if (idx_ok) out_reg_q[wr_ctx][wr_idx[IDX_W-1:0]] <= wr_data[REG_W-1:0];
                CF_NEED:   if (idx_ok) need_q[wr_ctx][wr_idx[IDX_W-1:0]] <= cnt_val;
                CF_LAT:    if (wr_idx <= GR_C) lat_q[wr_ctx][wr_idx] <= wr_data[LAT_W-1:0];
                default:   ;
            endcase
        end
    end

    // present the whole descriptor of the selected context
    always_comb begin
        rd_n_in  = n_in_q[rd_ctx];
        rd_n_out = n_out_q[rd_ctx];
        for (int i = 0; i < MAX_GR; i++) begin
            rd_in_reg[i]  = in_reg_q[rd_ctx][i];
            rd_out_reg[i] = out_reg_q[rd_ctx][i];
            rd_need[i]    = need_q[rd_ctx][i];
        end
        for (int k = 0; k <= MAX_GR; k++) begin
            rd_lat[k] = lat_q[rd_ctx][k];
        end
    end

endmodule

// File: rtl/gpk_op_former.sv
// Combinational opcode former. From the descriptor and the two progress
// pointers it builds the next opcode: source slots, result slots, latency,
// final flag and the advanced pointers.
// Assumes: in_ptr <= n_in <= MAX_GR and out_ptr <= n_out <= MAX_GR.
module gpk_op_former #(
    parameter int MAX_GR    = 8,
    parameter int MAX_IN    = 3,
    parameter int MAX_OUT1  = 1,
    parameter int MAX_OUT2  = 2,
    parameter int REG_W     = 5,
    parameter int LAT_W     = 4,
    localparam int CNT_W     = $clog2(MAX_GR + 1),
    localparam int OUT_SLOTS = (MAX_OUT1 > MAX_OUT2) ? MAX_OUT1 : MAX_OUT2
) (
    input  logic [CNT_W-1:0]           n_in,
    input  logic [CNT_W-1:0]           n_out,
    input  logic [REG_W-1:0]           in_reg  [MAX_GR],
    input  logic [REG_W-1:0]           out_reg [MAX_GR],
    input  logic [CNT_W-1:0]           need    [MAX_GR],
    input  logic [LAT_W-1:0]           lat_tab [MAX_GR+1],
    input  logic [CNT_W-1:0]           in_ptr,
    input  logic [CNT_W-1:0]           out_ptr,
    output logic [MAX_IN*REG_W-1:0]    f_in_reg,
    output logic [MAX_IN-1:0]          f_in_vld,
    output logic [OUT_SLOTS*REG_W-1:0] f_out_reg,
    output logic [OUT_SLOTS-1:0]       f_out_vld,
    output logic [LAT_W-1:0]           f_lat,
    output logic                       f_last,
    output logic [CNT_W-1:0]           nxt_in_ptr,
    output logic [CNT_W-1:0]           nxt_out_ptr
);
    localparam int SW    = CNT_W + 1;
    localparam int IDX_W = (MAX_GR > 1) ? $clog2(MAX_GR) : 1;

    logic          has_in;
    logic [SW-1:0] in_left;
    logic [SW-1:0] take;
    logic [SW-1:0] new_in_w;
    logic [SW-1:0] ocnt;
    logic [SW-1:0] new_out_w;

    // source slots: next group of sources in need order
    always_comb begin
        logic [SW-1:0] idx;
        has_in  = (in_ptr < n_in);
        in_left = {1'b0, n_in} - {1'b0, in_ptr};
        if (!has_in)                    take = '0;
        else if (in_left > SW'(MAX_IN)) take = SW'(MAX_IN);
        else                            take = in_left;
        new_in_w = {1'b0, in_ptr} + take;
        f_in_vld = '0;
        f_in_reg = '0;
        for (int i = 0; i < MAX_IN; i++) begin
            idx = {1'b0, in_ptr} + SW'(i);
            if (SW'(i) < take) begin
                f_in_vld[i] = 1'b1;
                f_in_reg[i*REG_W +: REG_W] = in_reg[idx[IDX_W-1:0]];
            end
        end
    end

    // result slots: contiguous ready results, capped by the opcode kind
    always_comb begin
        logic [SW-1:0] idx;
        logic          run;
        logic          ok;
        int            limit;
        limit     = has_in ? MAX_OUT1 : MAX_OUT2;
        run       = 1'b1;
        ocnt      = '0;
        f_out_vld = '0;
        f_out_reg = '0;
        for (int j = 0; j < OUT_SLOTS; j++) begin
            idx = {1'b0, out_ptr} + SW'(j);
            ok  = run && (j < limit) && (idx < {1'b0, n_out});
            if (ok && has_in) begin
                ok = ({1'b0, need[idx[IDX_W-1:0]]} <= new_in_w);
            end
            if (ok) begin
                f_out_vld[j] = 1'b1;
                f_out_reg[j*REG_W +: REG_W] = out_reg[idx[IDX_W-1:0]];
            end
            ocnt = ocnt + {{(SW-1){1'b0}}, ok};
            run  = ok;
        end
        new_out_w = {1'b0, out_ptr} + ocnt;
    end

    // latency tag, completion flag and advanced pointers
    always_comb begin
        f_lat       = has_in ? lat_tab[new_in_w[CNT_W-1:0]] : LAT_W'(1);
        f_last      = (new_in_w == {1'b0, n_in}) && (new_out_w == {1'b0, n_out});
        nxt_in_ptr  = new_in_w[CNT_W-1:0];
        nxt_out_ptr = new_out_w[CNT_W-1:0];
    end

    // assertion R11: a source slot is valid only where a source remains
    always_comb begin
        if (has_in) begin
            assert_src_in_range_R11: assert ({1'b0, nxt_in_ptr} <= {1'b0, n_in});
        end
    end

endmodule

// File: rtl/dfg_opcode_packer.sv
// Dataflow-graph opcode packer, top level.
// On a start pulse in idle it latches the context and walks the descriptor,
// presenting one opcode at a time on a valid/ready handshake until the final
// opcode is accepted, then returns to idle.
// Assumes: descriptors are written while idle and describe at most MAX_GR
// sources and MAX_GR results; every result's required count is >= 1 when the
// graph has sources.
module dfg_opcode_packer #(
    parameter int NUM_CTX  = 32,
    parameter int MAX_GR   = 8,
    parameter int MAX_IN   = 3,
    parameter int MAX_OUT1 = 1,
    parameter int MAX_OUT2 = 2,
    parameter int REG_W    = 5,
    parameter int LAT_W    = 4,
    parameter int CFG_DW   = 8,
    localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int CNT_W     = $clog2(MAX_GR + 1),
    localparam int OUT_SLOTS = (MAX_OUT1 > MAX_OUT2) ? MAX_OUT1 : MAX_OUT2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [CTX_W-1:0]           start_ctx,
    input  logic                       cfg_we,
    input  logic [CTX_W-1:0]           cfg_ctx,
    input  logic [2:0]                 cfg_sel,
    input  logic [CNT_W-1:0]           cfg_idx,
    input  logic [CFG_DW-1:0]          cfg_data,
    output logic                       busy,
    output logic                       op_valid,
    input  logic                       op_ready,
    output logic [CTX_W-1:0]           op_ctx,
    output logic [MAX_IN*REG_W-1:0]    op_in_reg,
    output logic [MAX_IN-1:0]          op_in_vld,
    output logic [OUT_SLOTS*REG_W-1:0] op_out_reg,
    output logic [OUT_SLOTS-1:0]       op_out_vld,
    output logic [LAT_W-1:0]           op_lat,
    output logic                       op_last
);
    import opk_pkg::*;

    pk_state_e        state_q;
    logic [CTX_W-1:0] ctx_q;
    logic [CNT_W-1:0] in_ptr_q;
    logic [CNT_W-1:0] out_ptr_q;

    logic [CNT_W-1:0] d_n_in;
    logic [CNT_W-1:0] d_n_out;
    logic [REG_W-1:0] d_in_reg  [MAX_GR];
    logic [REG_W-1:0] d_out_reg [MAX_GR];
    logic [CNT_W-1:0] d_need    [MAX_GR];
    logic [LAT_W-1:0] d_lat     [MAX_GR+1];

    logic [CNT_W-1:0] nxt_in;
    logic [CNT_W-1:0] nxt_out;
    logic             wr_ok;

    // table writes are accepted only while idle
    assign wr_ok = cfg_we && (state_q == ST_IDLE);

    gpk_desc_table #(
        .NUM_CTX(NUM_CTX), .MAX_GR(MAX_GR), .REG_W(REG_W),
        .LAT_W(LAT_W), .CFG_DW(CFG_DW)
    ) u_table (
        .clk       (clk),
        .wr_en     (wr_ok),
        .wr_ctx    (cfg_ctx),
        .wr_sel    (cfg_sel),
        .wr_idx    (cfg_idx),
        .wr_data   (cfg_data),
        .rd_ctx    (ctx_q),
        .rd_n_in   (d_n_in),
        .rd_n_out  (d_n_out),
        .rd_in_reg (d_in_reg),
        .rd_out_reg(d_out_reg),
        .rd_need   (d_need),
        .rd_lat    (d_lat)
    );

    gpk_op_former #(
        .MAX_GR(MAX_GR), .MAX_IN(MAX_IN), .MAX_OUT1(MAX_OUT1),
        .MAX_OUT2(MAX_OUT2), .REG_W(REG_W), .LAT_W(LAT_W)
    ) u_former (
        .n_in       (d_n_in),
        .n_out      (d_n_out),
        .in_reg     (d_in_reg),
        .out_reg    (d_out_reg),
        .need       (d_need),
        .lat_tab    (d_lat),
        .in_ptr     (in_ptr_q),
        .out_ptr    (out_ptr_q),
        .f_in_reg   (op_in_reg),
        .f_in_vld   (op_in_vld),
        .f_out_reg  (op_out_reg),
        .f_out_vld  (op_out_vld),
        .f_lat      (op_lat),
        .f_last     (op_last),
        .nxt_in_ptr (nxt_in),
        .nxt_out_ptr(nxt_out)
    );

    // sequencer: latch context on start, advance pointers on each handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ctx_q     <= '0;
            in_ptr_q  <= '0;
            out_ptr_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        ctx_q     <= start_ctx;
                        in_ptr_q  <= '0;
                        out_ptr_q <= '0;
                        state_q   <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (op_ready) begin
                        in_ptr_q  <= nxt_in;
                        out_ptr_q <= nxt_out;
                        if (op_last) state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // status and context outputs
    assign busy     = (state_q == ST_RUN);
    assign op_valid = (state_q == ST_RUN);
    assign op_ctx   = ctx_q;

    // R7: a stalled opcode holds every field
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_ready |=> op_valid && $stable(op_in_reg) && $stable(op_in_vld)
            && $stable(op_out_reg) && $stable(op_out_vld) && $stable(op_lat)
            && $stable(op_last) && $stable(op_ctx));

    // R8 and R5: while busy and not finishing, the graph and its context stay
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !(op_ready && op_last) |=> busy && $stable(op_ctx));

    // R6: accepting the final opcode returns the block to idle
    assert_end_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_ready && op_last |=> !busy && !op_valid);

    // R10: reset leaves the block idle
    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> !busy && !op_valid);

    // R1: source slots fill from slot 0 without gaps
    assert_src_packed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> ((op_in_vld & (op_in_vld + 1'b1)) == '0));

    // R2: an opcode with sources carries at most MAX_OUT1 results
    assert_out1_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && (|op_in_vld) |-> ($countones(op_out_vld) <= MAX_OUT1));

    // R3: output-only opcodes carry at most MAX_OUT2 results, packed from slot 0
    assert_out2_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !(|op_in_vld) |-> ($countones(op_out_vld) <= MAX_OUT2)
            && ((op_out_vld & (op_out_vld + 1'b1)) == '0));

    // R4: output-only opcodes are tagged with latency 1
    assert_lat_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !(|op_in_vld) |-> (op_lat == LAT_W'(1)));

endmodule

// File: tb/tb_dfg_opcode_packer.sv
// Self-checking bench: directed worked cases plus seeded random graphs,
// compared opcode by opcode against a sequence computed from the requirements.
module tb_dfg_opcode_packer;
    localparam int NUM_CTX = 32;
    localparam int MAX_GR  = 8;
    localparam int MAX_IN  = 3;
    localparam int MAX_O1  = 1;
    localparam int MAX_O2  = 2;
    localparam int REG_W   = 5;
    localparam int LAT_W   = 4;
    localparam int CFG_DW  = 8;
    localparam int CTX_W   = 5;
    localparam int CNT_W   = 4;
    localparam int OSL     = 2;

    logic clk, rst_n, start, cfg_we, busy, op_valid, op_ready, op_last;
    logic [CTX_W-1:0]     start_ctx, cfg_ctx, op_ctx;
    logic [2:0]           cfg_sel;
    logic [CNT_W-1:0]     cfg_idx;
    logic [CFG_DW-1:0]    cfg_data;
    logic [MAX_IN*REG_W-1:0] op_in_reg;
    logic [MAX_IN-1:0]    op_in_vld;
    logic [OSL*REG_W-1:0] op_out_reg;
    logic [OSL-1:0]       op_out_vld;
    logic [LAT_W-1:0]     op_lat;

    dfg_opcode_packer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_ctx(start_ctx),
        .cfg_we(cfg_we), .cfg_ctx(cfg_ctx), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .busy(busy), .op_valid(op_valid), .op_ready(op_ready),
        .op_ctx(op_ctx), .op_in_reg(op_in_reg), .op_in_vld(op_in_vld),
        .op_out_reg(op_out_reg), .op_out_vld(op_out_vld), .op_lat(op_lat),
        .op_last(op_last)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    int m_nin  [NUM_CTX];
    int m_nout [NUM_CTX];
    int m_in   [NUM_CTX][MAX_GR];
    int m_out  [NUM_CTX][MAX_GR];
    int m_need [NUM_CTX][MAX_GR];
    int m_lat  [NUM_CTX][MAX_GR+1];

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_wr(int c, int sel, int idx, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ctx = CTX_W'(c); cfg_sel = 3'(sel);
        cfg_idx = CNT_W'(idx); cfg_data = CFG_DW'(d);
    endtask

    task automatic load_ctx(int c);
        cfg_wr(c, 0, 0, m_nin[c]);
        cfg_wr(c, 1, 0, m_nout[c]);
        for (int i = 0; i < m_nin[c]; i++) cfg_wr(c, 2, i, m_in[c][i]);
        for (int j = 0; j < m_nout[c]; j++) begin
            cfg_wr(c, 3, j, m_out[c][j]);
            cfg_wr(c, 4, j, m_need[c][j]);
        end
        for (int k = 0; k <= MAX_GR; k++) cfg_wr(c, 5, k, m_lat[c][k]);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // expected next opcode, from the requirements
    task automatic expect_op(int c, int ip, int op,
                             output int e_iv, output int e_ir[MAX_IN],
                             output int e_ov, output int e_or[OSL],
                             output int e_lat, output int e_last,
                             output int n_ip, output int n_op);
        int take, k;
        e_iv = 0; e_ov = 0; k = 0;
        for (int i = 0; i < MAX_IN; i++) e_ir[i] = 0;
        for (int j = 0; j < OSL; j++) e_or[j] = 0;
        if (ip < m_nin[c]) begin
            take = m_nin[c] - ip;
            if (take > MAX_IN) take = MAX_IN;
            for (int i = 0; i < take; i++) begin
                e_ir[i] = m_in[c][ip+i];
                e_iv |= (1 << i);
            end
            n_ip = ip + take;
            while (k < MAX_O1 && op + k < m_nout[c] && m_need[c][op+k] <= n_ip) begin
                e_or[k] = m_out[c][op+k]; e_ov |= (1 << k); k++;
            end
            e_lat = m_lat[c][n_ip];
        end else begin
            n_ip = ip;
            while (k < MAX_O2 && op + k < m_nout[c]) begin
                e_or[k] = m_out[c][op+k]; e_ov |= (1 << k); k++;
            end
            e_lat = 1;
        end
        n_op   = op + k;
        e_last = (n_ip == m_nin[c] && n_op == m_nout[c]) ? 1 : 0;
    endtask

    // pack one graph; inject: 1 = start while busy, 2 = table write while busy
    task automatic run_graph(int c, bit stalls, int inject, output int nops);
        int ip, op, e_iv, e_ov, e_lat, e_last, n_ip, n_op, steps;
        int e_ir[MAX_IN];
        int e_or[OSL];
        bit done;
        logic [MAX_IN*REG_W-1:0] s_ir;
        logic [OSL*REG_W-1:0]    s_or;
        logic [LAT_W-1:0]        s_lat;
        @(negedge clk);
        start = 1'b1; start_ctx = CTX_W'(c);
        @(negedge clk);
        start = 1'b0;
        ip = 0; op = 0; steps = 0; done = 1'b0;
        while (!done && steps < 40) begin
            expect_op(c, ip, op, e_iv, e_ir, e_ov, e_or, e_lat, e_last, n_ip, n_op);
            chk("R6", "op_valid while packing", int'(op_valid), 1);
            chk("R5", "op_ctx", int'(op_ctx), c);
            chk("R1", "source valid bits", int'(op_in_vld), e_iv);
            for (int i = 0; i < MAX_IN; i++)
                chk((e_iv >> i) & 1 ? "R1" : "R11", "source field",
                    int'(op_in_reg[i*REG_W +: REG_W]), e_ir[i]);
            chk(e_iv != 0 ? "R2" : "R3", "result valid bits", int'(op_out_vld), e_ov);
            for (int j = 0; j < OSL; j++)
                chk((e_ov >> j) & 1 ? "R2" : "R11", "result field",
                    int'(op_out_reg[j*REG_W +: REG_W]), e_or[j]);
            chk("R4", "latency", int'(op_lat), e_lat);
            chk("R6", "last flag", int'(op_last), e_last);
            if (stalls && ($urandom % 3 == 0)) begin
                op_ready = 1'b0;
                s_ir = op_in_reg; s_or = op_out_reg; s_lat = op_lat;
                @(negedge clk);
                chk("R7", "stall hold", int'(op_valid && s_ir == op_in_reg &&
                    s_or == op_out_reg && s_lat == op_lat && op_last == 1'(e_last)), 1);
            end
            op_ready = 1'b1;
            if (steps == 0 && inject == 1) begin
                start = 1'b1; start_ctx = CTX_W'((c + 7) % NUM_CTX);
            end
            if (steps == 0 && inject == 2) begin
                cfg_we = 1'b1; cfg_ctx = CTX_W'(c); cfg_sel = 3'd2;
                cfg_idx = CNT_W'(m_nin[c] - 1); cfg_data = CFG_DW'(m_in[c][m_nin[c]-1] ^ 31);
            end
            @(negedge clk);
            start = 1'b0; cfg_we = 1'b0;
            ip = n_ip; op = n_op; done = (e_last != 0); steps++;
        end
        nops = steps;
        chk("R6", "idle after final opcode", int'(busy || op_valid), 0);
    endtask

    task automatic rand_ctx(int c);
        m_nin[c]  = $urandom_range(0, MAX_GR);
        m_nout[c] = $urandom_range(0, MAX_GR);
        for (int i = 0; i < MAX_GR; i++) begin
            m_in[c][i]   = $urandom_range(0, 31);
            m_out[c][i]  = $urandom_range(0, 31);
            m_need[c][i] = (m_nin[c] == 0) ? 0 : $urandom_range(1, m_nin[c]);
        end
        for (int k = 0; k <= MAX_GR; k++) m_lat[c][k] = $urandom_range(1, 15);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int nops;
        void'($urandom(32'd4242));
        rst_n = 1'b0; start = 1'b0; start_ctx = '0; cfg_we = 1'b0; cfg_ctx = '0;
        cfg_sel = '0; cfg_idx = '0; cfg_data = '0; op_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "busy in reset", int'(busy), 0);
        chk("R10", "valid in reset", int'(op_valid), 0);
        rst_n = 1'b1;

        for (int c = 0; c < NUM_CTX; c++) rand_ctx(c);
        // ctx 0: inputs A..D, outputs X(3) Z(4) Y(4)
        m_nin[0] = 4; m_nout[0] = 3;
        for (int i = 0; i < 4; i++) m_in[0][i] = 1 + i;
        m_out[0][0] = 10; m_need[0][0] = 3;
        m_out[0][1] = 11; m_need[0][1] = 4;
        m_out[0][2] = 12; m_need[0][2] = 4;
        // ctx 1: inputs A..C, outputs X Y Z all ready after 3
        m_nin[1] = 3; m_nout[1] = 3;
        for (int j = 0; j < 3; j++) begin m_out[1][j] = 20 + j; m_need[1][j] = 3; end
        // ctx 2: five sources, no results
        m_nin[2] = 5; m_nout[2] = 0;
        // ctx 3: empty graph
        m_nin[3] = 0; m_nout[3] = 0;
        // ctx 4: no sources, five results
        m_nin[4] = 0; m_nout[4] = 5;
        // ctx 5: first result late, later one early: scan must stop
        m_nin[5] = 6; m_nout[5] = 3;
        m_need[5][0] = 6; m_need[5][1] = 1; m_need[5][2] = 6;
        for (int c = 0; c < NUM_CTX; c++) load_ctx(c);

        run_graph(0, 1'b0, 0, nops);
        chk("R2", "worked case 1 opcode count", nops, 3);
        run_graph(1, 1'b0, 0, nops);
        chk("R3", "worked case 2 opcode count", nops, 2);
        run_graph(2, 1'b0, 0, nops);
        chk("R6", "no-result graph opcode count", nops, 2);
        run_graph(3, 1'b0, 0, nops);
        chk("R6", "empty graph opcode count", nops, 1);
        run_graph(4, 1'b0, 0, nops);
        chk("R3", "output-only graph opcode count", nops, 3);
        run_graph(5, 1'b1, 0, nops);
        run_graph(31, 1'b1, 0, nops);

        // R8: start while busy is ignored
        run_graph(0, 1'b0, 1, nops);
        chk("R8", "opcodes with start while busy", nops, 3);
        // R9: table write while busy is ignored, then rerun reads old value
        run_graph(2, 1'b0, 2, nops);
        run_graph(2, 1'b0, 0, nops);
        chk("R9", "opcode count after ignored write", nops, 2);

        // R10: reset mid-graph, table kept
        @(negedge clk); start = 1'b1; start_ctx = 5'd0;
        @(negedge clk); start = 1'b0;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R10", "idle after mid-graph reset", int'(busy || op_valid), 0);
        run_graph(0, 1'b0, 0, nops);
        chk("R10", "table kept across reset", nops, 3);

        for (int t = 0; t < 80; t++) begin
            int c;
            c = $urandom_range(6, NUM_CTX - 1);
            if (t % 10 == 0) begin rand_ctx(c); load_ctx(c); end
            run_graph(c, 1'b1, (t % 7 == 3) ? 1 : 0, nops);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule